// File: doc/BRIEF.md
# Video RAM CPU access port

This block is the processor-facing side of a tile-based video display processor that owns a byte-wide video RAM. The processor reaches the RAM through two byte ports. On the data port, each written byte is parked in a single holding latch. An access-slot arbiter later moves that byte into the RAM at the current address and then steps the address by one. The control port takes two-byte commands. A command either loads the RAM address or writes one of the mode registers. A status port reports that the display has entered vertical blank.

The slot arbiter follows the display phase. During active display, a slot for the processor comes round only once every `SLOT_CYC` clock cycles. During vertical blank, or while the display-enable bit is cleared, a pending byte is committed on the very next clock. The latch has no full indication. A processor that writes faster than the slots arrive silently loses bytes: each new byte replaces the one still waiting. Correct software must therefore space its writes to at least one slot period during active display. Alternatively, it can do bulk transfers during blanking or with the display switched off.

Display timing is taken from an internal frame counter of `ACTIVE_CYC + BLANK_CYC` cycles, with the blanking part last. The RAM is a behavioural array. It is read back combinationally through a peek port.

Top module: `vram_cpu_port`

## Requirements
- R1: After reset the status byte is 0x00, no byte is pending, the control port expects the first byte of a command, and the display-enable bit is 0, so that data writes commit immediately.
- R2: A data-port write stores its byte in the holding latch. The byte is written to RAM at the current address when the next slot is granted, and the address then increases by one.
- R3: A data-port write that arrives while a byte is still pending replaces that byte without any indication. The replaced byte never reaches RAM, and the byte written last is always committed.
- R4: During active display with the display enabled, slots occur every `SLOT_CYC` cycles. A pending byte therefore waits fewer than `SLOT_CYC` cycles, and writes spaced `SLOT_CYC` or more cycles apart all land in order.
- R5: During vertical blank, or while the display-enable bit is 0, a pending byte is committed on the next clock edge, so writes on consecutive cycles all land.
- R6: A control command whose second byte has bit 7 set writes the first byte into the mode register numbered by bits 2:0 of the second byte. Bit 6 of mode register 1 is display enable (value 0xE2 then command 0x81 enables; 0x02 then 0x81 disables).
- R7: A control command whose second byte has bit 7 clear loads the RAM address. The first byte supplies address bits 7:0 and bits 5:0 of the second byte supply address bits 13:8. Bit 6 selects write (1) or read (0) and has no other effect here.
- R8: Status bit 7 is set on the first cycle of vertical blank, once per frame of `ACTIVE_CYC + BLANK_CYC` cycles. It stays set until it is read. Status bits 6:0 read as 0.
- R9: A status read clears status bit 7 (a new blank start in the same cycle wins) and returns the control port to expecting the first byte of a command.
- R10: The RAM address is `ADDR_W` bits wide. Higher loaded bits are dropped, and auto-increment wraps from the top address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_wr | input | 1 | Data-port write strobe, one cycle per byte |
| ctrl_wr | input | 1 | Control-port write strobe, one cycle per byte |
| stat_rd | input | 1 | Status-port read strobe |
| cpu_wdata | input | 8 | Byte written on the data or control port |
| stat_out | output | 8 | Status byte, bit 7 = vertical blank seen |
| peek_addr | input | ADDR_W | RAM read-back address |
| peek_data | output | 8 | RAM content at `peek_addr` |

## Verification
The bench runs a shortened frame with a six-cycle slot. It aims at the cases where a port of this kind goes wrong.

- Writes five cycles apart in active display must lose at least one byte. The survivors must rise in order and end with the last byte. A latch that queued, or one that kept the old byte, would fail this.
- Writes eight cycles apart must all land. This exposes a slot that comes too rarely.
- Bursts on consecutive cycles during blanking, and with the display disabled, must all land. A design that ignored the immediate-commit rule would drop them.
- A stray control byte followed by a status read must not shift the next address command, which catches a phase that is not reset.
- An increment past the top address must wrap to 0.
- The frame-period measurement catches an off-by-one in the frame counter.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } ctl_phase_e;

   localparam int unsigned DISP_REG_NUM = 1;
   localparam int unsigned DISP_EN_BIT  = 6;
   localparam int unsigned CMD_ADDR_W   = 14;

endpackage

// File: rtl/vcp_display_timer.sv
module vcp_display_timer #(
   parameter int unsigned ACTIVE_CYC = 300,
   parameter int unsigned BLANK_CYC  = 60,
   parameter int unsigned SLOT_CYC   = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic in_blank,
   output logic blank_start,
   output logic slot_tick
);

   localparam int unsigned FRAME_CYC = ACTIVE_CYC + BLANK_CYC;
   localparam int unsigned FW        = $clog2(FRAME_CYC);

   if (ACTIVE_CYC < 1 || BLANK_CYC < 1) begin : g_bad_frame
      $error("vcp_display_timer: active and blank lengths must be non-zero");
   end
   if (SLOT_CYC < 1) begin : g_bad_slot
      $error("vcp_display_timer: slot period must be at least one cycle");
   end

   logic [FW-1:0] frame_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
      end else if (frame_q == FW'(FRAME_CYC - 1)) begin
         frame_q <= '0;
      end else begin
         frame_q <= frame_q + 1'b1;
      end
   end

   assign in_blank    = (frame_q >= FW'(ACTIVE_CYC));
   assign blank_start = (frame_q == FW'(ACTIVE_CYC));

   if (SLOT_CYC == 1) begin : g_slot_always
      assign slot_tick = 1'b1;
   end else begin : g_slot_div
      localparam int unsigned SW = $clog2(SLOT_CYC);
      logic [SW-1:0] slot_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (slot_q == SW'(SLOT_CYC - 1)) begin
            slot_q <= '0;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end

      assign slot_tick = (slot_q == '0);

      // R4: a slot is never followed by another one on the next cycle
      p_slot_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
         slot_tick |=> !slot_tick);
   end

   // R8: the first blanking cycle is followed by further blanking
   p_blank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      blank_start |=> in_blank);

endmodule

// File: rtl/vcp_ctrl_port.sv
module vcp_ctrl_port
   import vcp_pkg::*;
#(
   parameter int unsigned ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              stat_rd,
   input  logic [7:0]        cpu_wdata,
   input  logic              commit,
   output logic [ADDR_W-1:0] vram_addr,
   output logic              disp_en
);

   if (ADDR_W < 4 || ADDR_W > CMD_ADDR_W) begin : g_bad_addr
      $error("vcp_ctrl_port: ADDR_W must lie between 4 and 14");
   end

   ctl_phase_e          ph_q;
   logic [7:0]          lo_q;
   logic [7:0]          mode1_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [CMD_ADDR_W-1:0] cmd_addr;
   logic                second_byte;
   logic                addr_load;
   logic                reg_load;
   logic                unused_bits;

   assign second_byte = ctrl_wr && !stat_rd && (ph_q == PH_SECOND);
   assign addr_load   = second_byte && !cpu_wdata[7];
   assign reg_load    = second_byte && cpu_wdata[7] &&
                        (cpu_wdata[2:0] == 3'(DISP_REG_NUM));
   assign cmd_addr    = {cpu_wdata[5:0], lo_q};
   assign unused_bits = ^{cpu_wdata[6], cmd_addr, mode1_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= PH_FIRST;
         lo_q    <= '0;
         mode1_q <= '0;
      end else if (stat_rd) begin
         ph_q <= PH_FIRST;
      end else if (ctrl_wr) begin
         if (ph_q == PH_FIRST) begin
            lo_q <= cpu_wdata;
            ph_q <= PH_SECOND;
         end else begin
            ph_q <= PH_FIRST;
            if (reg_load) begin
               mode1_q <= lo_q;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (addr_load) begin
         addr_q <= cmd_addr[ADDR_W-1:0];
      end else if (commit) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   assign vram_addr = addr_q;
   assign disp_en   = mode1_q[DISP_EN_BIT];

   // R9: a status read always leaves the port expecting a first byte
   p_phase_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> (ph_q == PH_FIRST));

   // R2: a commit without an address load steps the address by one
   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !addr_load) |=> (addr_q == $past(addr_q) + 1'b1));

   // R7: without commit or load the address holds
   p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !addr_load) |=> $stable(addr_q));

endmodule

// File: rtl/vcp_data_latch.sv
module vcp_data_latch #(
   parameter int unsigned ADDR_W   = 11,
   parameter int unsigned SLOT_CYC = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic [7:0]        cpu_wdata,
   input  logic              slot_tick,
   input  logic              immediate,
   input  logic [ADDR_W-1:0] vram_addr,
   output logic              commit,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [7:0]        peek_data
);

   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned WW    = $clog2(SLOT_CYC + 1) + 1;

   logic [7:0]    hold_q;
   logic          pend_q;
   logic [7:0]    mem [DEPTH];
   logic [WW-1:0] wait_q;

   assign commit = pend_q && (immediate || slot_tick);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         hold_q <= '0;
      end else if (data_wr) begin
         hold_q <= cpu_wdata;
         pend_q <= 1'b1;
      end else if (commit) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (commit) begin
         mem[vram_addr] <= hold_q;
      end
   end

   assign peek_data = mem[peek_addr];

   // cycle counter used only to bound the slot wait
   always_ff @(posedge clk) begin
      if (!rst_n || data_wr || commit) begin
         wait_q <= '0;
      end else if (pend_q && wait_q != '1) begin
         wait_q <= wait_q + 1'b1;
      end
   end

   // R4: a pending byte waits fewer than SLOT_CYC cycles
   p_slot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (wait_q < WW'(SLOT_CYC)));

   // R3: a data write always leaves the newest byte pending
   p_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> (pend_q && hold_q == $past(cpu_wdata)));

   // R5: in immediate mode a pending byte leaves on the next edge
   p_immediate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && immediate && !data_wr) |=> !pend_q);

endmodule

// File: rtl/vram_cpu_port.sv
module vram_cpu_port #(
   parameter int unsigned ADDR_W     = 11,
   parameter int unsigned ACTIVE_CYC = 2_880_000,
   parameter int unsigned BLANK_CYC  = 460_000,
   parameter int unsigned SLOT_CYC   = 1200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic              ctrl_wr,
   input  logic              stat_rd,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        stat_out,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [7:0]        peek_data
);

   logic              in_blank;
   logic              blank_start;
   logic              slot_tick;
   logic              disp_en;
   logic              commit;
   logic [ADDR_W-1:0] vram_addr;
   logic              vbl_flag_q;

   vcp_display_timer #(
      .ACTIVE_CYC (ACTIVE_CYC),
      .BLANK_CYC  (BLANK_CYC),
      .SLOT_CYC   (SLOT_CYC)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_blank    (in_blank),
      .blank_start (blank_start),
      .slot_tick   (slot_tick)
   );

   vcp_ctrl_port #(
      .ADDR_W (ADDR_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (ctrl_wr),
      .stat_rd   (stat_rd),
      .cpu_wdata (cpu_wdata),
      .commit    (commit),
      .vram_addr (vram_addr),
      .disp_en   (disp_en)
   );

   vcp_data_latch #(
      .ADDR_W   (ADDR_W),
      .SLOT_CYC (SLOT_CYC)
   ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_wr   (data_wr),
      .cpu_wdata (cpu_wdata),
      .slot_tick (slot_tick),
      .immediate (in_blank || !disp_en),
      .vram_addr (vram_addr),
      .commit    (commit),
      .peek_addr (peek_addr),
      .peek_data (peek_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vbl_flag_q <= 1'b0;
      end else if (blank_start) begin
         vbl_flag_q <= 1'b1;
      end else if (stat_rd) begin
         vbl_flag_q <= 1'b0;
      end
   end

   assign stat_out = {vbl_flag_q, 7'b0};

   // R9: a status read clears the flag unless blanking starts again
   p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !blank_start) |=> !stat_out[7]);

   // R8: the flag rises only at the start of blanking
   p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_out[7]) |-> $past(blank_start));

endmodule

// File: tb/vram_cpu_port_bench.sv
module vram_cpu_port_bench;

   localparam int unsigned AW  = 10;
   localparam int unsigned ACT = 300;
   localparam int unsigned BLK = 60;
   localparam int unsigned SLT = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          data_wr = 1'b0;
   logic          ctrl_wr = 1'b0;
   logic          stat_rd = 1'b0;
   logic [7:0]    cpu_wdata = '0;
   logic [7:0]    stat_out;
   logic [AW-1:0] peek_addr = '0;
   logic [7:0]    peek_data;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   vram_cpu_port #(
      .ADDR_W     (AW),
      .ACTIVE_CYC (ACT),
      .BLANK_CYC  (BLK),
      .SLOT_CYC   (SLT)
   ) u_vram_cpu_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_wr   (data_wr),
      .ctrl_wr   (ctrl_wr),
      .stat_rd   (stat_rd),
      .cpu_wdata (cpu_wdata),
      .stat_out  (stat_out),
      .peek_addr (peek_addr),
      .peek_data (peek_data)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cw(input logic [7:0] b);
      ctrl_wr = 1'b1; cpu_wdata = b;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic dw(input logic [7:0] b);
      data_wr = 1'b1; cpu_wdata = b;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   task automatic rd_stat();
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic set_addr(input logic [13:0] a);
      cw(a[7:0]);
      cw({2'b01, a[13:8]});
   endtask

   task automatic peek(input logic [AW-1:0] a, output logic [7:0] v);
      peek_addr = a;
      #1;
      v = peek_data;
   endtask

   task automatic wait_blank();
      rd_stat();
      while (stat_out[7] !== 1'b1) @(negedge clk);
   endtask

   task automatic enter_active();
      repeat (BLK + 4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] prev;
      int n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state of the status byte
      chk("R1 status after reset", stat_out, 8'h00);

      // R1/R5: display disabled after reset, so a write commits at once
      set_addr(14'h010);
      dw(8'h5A);
      @(negedge clk);
      peek(10'h010, v);
      chk("R1 immediate commit out of reset", v, 8'h5A);

      // R6: enable the display
      cw(8'hE2);
      cw(8'h81);

      // R8: measure the frame period between two flag rises
      wait_blank();
      rd_stat();
      chk("R8 flag cleared by read", stat_out, 8'h00);
      n = 1;
      while (stat_out[7] !== 1'b1) begin
         @(negedge clk);
         n++;
      end
      chk("R8 frame period", n, ACT + BLK);

      // R9/R7: stray byte, status read, then a clean address command
      cw(8'h77);
      rd_stat();
      set_addr(14'h123);
      dw(8'hA5);
      @(negedge clk);
      peek(10'h123, v);
      chk("R9 phase reset before address set", v, 8'hA5);

      // prefill regions used for loss checks, during blanking
      wait_blank();
      set_addr(14'h200);
      for (int i = 0; i < 16; i++) dw(8'h00);
      set_addr(14'h300);
      for (int i = 0; i < 4; i++) dw(8'h00);

      // R3: writes five cycles apart in active display lose bytes
      wait_blank();
      enter_active();
      set_addr(14'h200);
      for (int i = 1; i <= 12; i++) begin
         dw(8'(i));
         repeat (4) @(negedge clk);
      end
      repeat (10) @(negedge clk);
      n = 0;
      prev = 8'h00;
      for (int i = 0; i < 12; i++) begin
         peek(10'(12'h200 + i), v);
         if (v != 8'h00 && n == i) begin
            chk("R3 surviving bytes ascend", int'(v > prev), 1);
            prev = v;
            n++;
         end
      end
      chk("R3 some bytes dropped", int'(n < 12), 1);
      chk("R3 last byte survives", prev, 8'd12);

      // R4/R2: writes eight cycles apart all land in order
      wait_blank();
      enter_active();
      set_addr(14'h240);
      for (int i = 0; i < 12; i++) begin
         dw(8'(8'h40 + i));
         repeat (7) @(negedge clk);
      end
      repeat (10) @(negedge clk);
      for (int i = 0; i < 12; i++) begin
         peek(10'(12'h240 + i), v);
         chk("R4 spaced write lands", v, 8'h40 + i);
      end

      // R5: back-to-back burst during blanking
      wait_blank();
      set_addr(14'h280);
      for (int i = 0; i < 20; i++) dw(8'(8'h80 + i));
      repeat (3) @(negedge clk);
      for (int i = 0; i < 20; i++) begin
         peek(10'(12'h280 + i), v);
         chk("R5 blanking burst lands", v, 8'h80 + i);
      end

      // R6/R5: display disabled in active display, burst still lands
      wait_blank();
      enter_active();
      cw(8'h02);
      cw(8'h81);
      set_addr(14'h2C0);
      for (int i = 0; i < 10; i++) dw(8'(8'hC0 + i));
      repeat (3) @(negedge clk);
      for (int i = 0; i < 10; i++) begin
         peek(10'(12'h2C0 + i), v);
         chk("R6 display-off burst lands", v, 8'hC0 + i);
      end

      // R6: re-enabled display brings slot waiting back
      cw(8'hE2);
      cw(8'h81);
      set_addr(14'h300);
      dw(8'hD1);
      dw(8'hD2);
      dw(8'hD3);
      repeat (10) @(negedge clk);
      peek(10'h302, v);
      chk("R6 re-enabled display drops burst", v, 8'h00);

      // R10: increment wraps from the top address to zero
      wait_blank();
      set_addr(14'h3FF);
      dw(8'hEE);
      dw(8'hEF);
      @(negedge clk);
      peek(10'h3FF, v);
      chk("R10 top address", v, 8'hEE);
      peek(10'h000, v);
      chk("R10 wrapped address", v, 8'hEF);

      // R10: upper address bits beyond ADDR_W are dropped
      set_addr(14'h2C05);
      dw(8'h3C);
      @(negedge clk);
      peek(10'h005, v);
      chk("R10 upper bits dropped", v, 8'h3C);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule